// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This block turns a system clock into the bit clock of a CAN node. A free-running prescaler produces time quanta. A segment sequencer builds every nominal bit from a one-quantum sync segment, a propagation segment and two phase segments. At the end of the first phase segment it samples the receive line, using either one sample or a majority vote of three. It hands the sampled bit to the protocol sequencer together with a one-cycle sample strobe. It also raises a transmit strobe whenever a new bit begins, so the sequencer can drive its next bit onto the line.

The receive line is evaluated once per quantum. A falling edge (recessive 1 to dominant 0) while the sequencer reports an idle bus restarts the bit at once, which is hard synchronization. A falling edge at any other time stretches or shrinks the current bit by the measured phase error, clipped to the jump width, which is resynchronization. Resynchronization is skipped while the node itself drives a dominant bit. At most one synchronization is taken between two sample points.

Top module: `can_bit_timing`

## Requirements
- R1: One time quantum lasts 2*(cfg_brp+1) system clocks, with cfg_brp a 6-bit value.
- R2: With no falling edge on rx_in, consecutive sample strobes, and consecutive transmit strobes, are (1+P+A+B) quanta apart. P=cfg_prop+1, A=cfg_ph1+1 and B=cfg_ph2+1 are the segment lengths, and cfg_ph2 must be at least 1.
- R3: sample_stb pulses (1+P+A) quanta after tx_stb, at the end of the first phase segment. rx_bit takes the sampled value in the same cycle and holds it until the next sample strobe.
- R4: sample_stb and tx_stb are one-cycle pulses that never coincide. tx_stb marks the start of each bit.
- R5: A falling edge detected in quantum n of the bit, with 1 <= n <= P+A, lengthens the first phase segment by min(n, J) quanta, where J=cfg_sjw+1 (1..4).
- R6: A falling edge in the second phase segment has phase error e equal to the number of quanta of that segment from the edge quantum to its end. If e <= J, the edge quantum becomes the sync segment of a new bit, and tx_stb is raised at its end. Otherwise the second phase segment is shortened by J quanta.
- R7: While tx_bit is 0 (dominant), falling edges cause no resynchronization.
- R8: After one synchronization, further falling edges are ignored until the next sample strobe.
- R9: While bus_idle is 1, a falling edge in any quantum makes that quantum the sync segment of a new bit. The edge is used regardless of tx_bit and of R8, and no strobe is raised for it.
- R10: With cfg_triple=1, the sampled bit is the majority of the line values at the ends of the last three quanta up to the sample point. With cfg_triple=0, it is the value at the end of the last quantum only.
- R11: During and right after reset, rx_bit is 1 and both strobes are 0.
- R12: rx_in passes through one register and is compared only at quantum boundaries. A low pulse that does not cover a quantum boundary is neither an edge nor a sampled value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_brp | input | 6 | Quantum prescaler value |
| cfg_prop | input | 3 | Propagation segment length minus one |
| cfg_ph1 | input | 3 | First phase segment length minus one |
| cfg_ph2 | input | 3 | Second phase segment length minus one (1..7) |
| cfg_sjw | input | 2 | Jump width minus one |
| cfg_triple | input | 1 | 1 selects three-sample majority |
| bus_idle | input | 1 | Arms hard synchronization |
| rx_in | input | 1 | Raw receive line, 0 dominant |
| tx_bit | input | 1 | Bit the node drives now, 0 dominant |
| rx_bit | output | 1 | Last sampled bit value |
| sample_stb | output | 1 | One-cycle pulse at each sample point |
| tx_stb | output | 1 | One-cycle pulse at each bit start |

## Verification
Each strobe is registered, so it appears in the clock after the quantum boundary that produces it. The bench therefore takes the cycle index at which tx_stb is seen as the origin of the bit and expects a sample strobe exactly k quanta later, where k follows from R3, R5, R6 and R9. Stimulus on rx_in is applied just after a falling clock edge at a multiple of the quantum length past that origin. The input register then places the edge inside quantum n, and the quantum boundary that follows sees it. The scoreboard compares the cycle and the value of every sample strobe against these predictions in order.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/can_bt_quantum.sv
module can_bt_quantum #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] brp,
    output logic             tick
);
    localparam int PW = BRP_W + 1;

    logic [PW-1:0] pcnt_d, pcnt_q;
    logic [PW-1:0] last;

    // quantum = 2*(brp+1) clocks, so the counter wraps at 2*brp+1
    assign last = {brp, 1'b1};
    assign tick = (pcnt_q >= last);

    always_comb begin
        pcnt_d = tick ? '0 : pcnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end
endmodule

// File: rtl/can_bt_rxfront.sv
module can_bt_rxfront
    import can_bt_pkg::*;
#(
    parameter int TAPS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    input  logic tick,
    output logic rx_now,
    output logic fall,
    output logic voted
);
    localparam int HW = TAPS - 1;

    typedef struct packed {
        logic          rx_s;
        logic          last;
        logic [HW-1:0] hist;
    } fr_t;

    fr_t d, q;

    always_comb begin
        d      = q;
        d.rx_s = rx_in;
        if (tick) begin
            d.last = q.rx_s;
            d.hist = {q.hist[HW-2:0], q.rx_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign rx_now = q.rx_s;
    assign fall   = tick & q.last & ~q.rx_s;
    assign voted  = vote3(q.hist[1], q.hist[0], q.rx_s);
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
    import can_bt_pkg::*;
#(
    parameter int BRP_W = 6,
    parameter int SEG_W = 3,
    parameter int SJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] cfg_brp,
    input  logic [SEG_W-1:0] cfg_prop,
    input  logic [SEG_W-1:0] cfg_ph1,
    input  logic [SEG_W-1:0] cfg_ph2,
    input  logic [SJW_W-1:0] cfg_sjw,
    input  logic             cfg_triple,
    input  logic             bus_idle,
    input  logic             rx_in,
    input  logic             tx_bit,
    output logic             rx_bit,
    output logic             sample_stb,
    output logic             tx_stb
);
    localparam int CNT_W = SEG_W + 1;
    localparam int EW    = CNT_W + 1;
    localparam int XW    = SJW_W + 1;
    localparam logic [EW-1:0] ONE = EW'(1);

    typedef struct packed {
        seg_e             seg;
        logic [CNT_W-1:0] cnt;
        logic [XW-1:0]    ext;
        logic [XW-1:0]    shr;
        logic             synced;
        logic             smp;
        logic             txs;
        logic             bit_v;
    } st_t;

    st_t d, q;

    logic tq_tick;
    logic rx_now, fall, voted;
    logic hard, resync;
    logic [EW-1:0] len_p, len_b, sjw_l, cnt_e, err_late, err_early, ph1_len;

    can_bt_quantum #(.BRP_W(BRP_W)) u_quantum (
        .clk   (clk),
        .rst_n (rst_n),
        .brp   (cfg_brp),
        .tick  (tq_tick)
    );

    can_bt_rxfront #(.TAPS(3)) u_rxfront (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_in  (rx_in),
        .tick   (tq_tick),
        .rx_now (rx_now),
        .fall   (fall),
        .voted  (voted)
    );

    assign len_p     = EW'(cfg_prop) + ONE;
    assign len_b     = EW'(cfg_ph2) + ONE;
    assign sjw_l     = EW'(cfg_sjw) + ONE;
    assign cnt_e     = EW'(q.cnt);
    assign err_late  = (q.seg == SEG_PROP) ? cnt_e + ONE : len_p + cnt_e + ONE;
    assign err_early = len_b - cnt_e;
    assign hard      = fall & bus_idle;
    assign resync    = fall & ~bus_idle & tx_bit & ~q.synced;

    always_comb begin
        d       = q;
        d.smp   = 1'b0;
        d.txs   = 1'b0;
        ph1_len = '0;
        if (tq_tick) begin
            if (hard) begin
                // edge quantum served as the sync segment of a new bit
                d.seg    = SEG_PROP;
                d.cnt    = '0;
                d.ext    = '0;
                d.shr    = '0;
                d.synced = 1'b1;
            end else begin
                case (q.seg)
                    SEG_SYNC: begin
                        if (resync) d.synced = 1'b1;
                        d.seg = SEG_PROP;
                        d.cnt = '0;
                    end
                    SEG_PROP: begin
                        if (resync) begin
                            d.ext    = XW'((err_late < sjw_l) ? err_late : sjw_l);
                            d.synced = 1'b1;
                        end
                        if (cnt_e + ONE >= len_p) begin
                            d.seg = SEG_PH1;
                            d.cnt = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                    SEG_PH1: begin
                        if (resync) begin
                            d.ext    = XW'((err_late < sjw_l) ? err_late : sjw_l);
                            d.synced = 1'b1;
                        end
                        ph1_len = EW'(cfg_ph1) + ONE + EW'(d.ext);
                        if (cnt_e + ONE >= ph1_len) begin
                            d.seg    = SEG_PH2;
                            d.cnt    = '0;
                            d.smp    = 1'b1;
                            d.bit_v  = cfg_triple ? voted : rx_now;
                            d.synced = 1'b0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (resync && (err_early <= sjw_l)) begin
                            d.seg    = SEG_PROP;
                            d.cnt    = '0;
                            d.ext    = '0;
                            d.shr    = '0;
                            d.synced = 1'b1;
                            d.txs    = 1'b1;
                        end else begin
                            if (resync) begin
                                d.shr    = XW'(sjw_l);
                                d.synced = 1'b1;
                            end
                            if (cnt_e + ONE + EW'(d.shr) >= len_b) begin
                                d.seg = SEG_SYNC;
                                d.cnt = '0;
                                d.ext = '0;
                                d.shr = '0;
                                d.txs = 1'b1;
                            end else begin
                                d.cnt = q.cnt + 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.seg   <= SEG_SYNC;
            q.bit_v <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_bit     = q.bit_v;
    assign sample_stb = q.smp;
    assign tx_stb     = q.txs;
endmodule

// File: rtl/can_bit_timing_chk.sv
module can_bit_timing_chk (
    input logic clk,
    input logic rst_n,
    input logic tq_tick,
    input logic rx_bit,
    input logic sample_stb,
    input logic tx_stb
);
    a_r4_stb_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && tx_stb));

    a_r4_sample_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    a_r4_tx_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |=> !tx_stb);

    a_r3_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |-> $stable(rx_bit));

    a_r12_sample_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> $past(tq_tick));
endmodule

bind can_bit_timing can_bit_timing_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tq_tick    (tq_tick),
    .rx_bit     (rx_bit),
    .sample_stb (sample_stb),
    .tx_stb     (tx_stb)
);

// File: tb/can_bit_timing_test.sv
module can_bit_timing_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cfg_brp = 6'd0;
    logic [2:0] cfg_prop = 3'd1;
    logic [2:0] cfg_ph1 = 3'd2;
    logic [2:0] cfg_ph2 = 3'd2;
    logic [1:0] cfg_sjw = 2'd3;
    logic       cfg_triple = 1'b0;
    logic       bus_idle = 1'b0;
    logic       rx_in = 1'b1;
    logic       tx_bit = 1'b1;
    logic       rx_bit, sample_stb, tx_stb;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int qn      = 2;
    bit done    = 1'b0;
    int exp_t[$];
    bit exp_v[$];
    string exp_r[$];
    int mt;
    bit mv;
    string mr;

    can_bit_timing uut (
        .clk(clk), .rst_n(rst_n), .cfg_brp(cfg_brp), .cfg_prop(cfg_prop),
        .cfg_ph1(cfg_ph1), .cfg_ph2(cfg_ph2), .cfg_sjw(cfg_sjw),
        .cfg_triple(cfg_triple), .bus_idle(bus_idle), .rx_in(rx_in),
        .tx_bit(tx_bit), .rx_bit(rx_bit), .sample_stb(sample_stb), .tx_stb(tx_stb)
    );

    always #10 clk = ~clk;

    // monitor: pops the scoreboard on each sample strobe
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && sample_stb && exp_t.size() > 0) begin
            mt = exp_t.pop_front();
            mv = exp_v.pop_front();
            mr = exp_r.pop_front();
            n_tests++;
            if (cyc != mt) begin
                n_fail++;
                $display("FAIL %s sample cycle actual %0d expected %0d", mr, cyc, mt);
            end
            n_tests++;
            if (rx_bit !== mv) begin
                n_fail++;
                $display("FAIL %s rx_bit actual %0b expected %0b", mr, rx_bit, mv);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wait_bit(output int t);
        do begin
            @(negedge clk); #1;
        end while (!tx_stb);
        t = cyc;
    endtask

    task automatic goto(input int c);
        while (cyc < c) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic push(input int t, input bit v, input string r);
        exp_t.push_back(t);
        exp_v.push_back(v);
        exp_r.push_back(r);
    endtask

    task automatic drain();
        while (exp_t.size() > 0) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic setup(input int p, input int a, input int b, input int j,
                         input int brp, input bit tmode);
        int t;
        cfg_prop = 3'(p - 1); cfg_ph1 = 3'(a - 1); cfg_ph2 = 3'(b - 1);
        cfg_sjw = 2'(j - 1); cfg_brp = 6'(brp); cfg_triple = tmode;
        qn = 2 * (brp + 1);
        rx_in = 1'b1; tx_bit = 1'b1; bus_idle = 1'b0;
        repeat (3) wait_bit(t);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int t, t2;
        repeat (4) @(negedge clk);
        check(rx_bit === 1'b1, "R11 rx_bit in reset", int'(rx_bit), 1);
        @(negedge clk); #1 rst_n = 1'b1;
        @(negedge clk); #1;
        check(sample_stb === 1'b0, "R11 sample_stb after reset", int'(sample_stb), 0);
        check(tx_stb === 1'b0, "R11 tx_stb after reset", int'(tx_stb), 0);
        check(rx_bit === 1'b1, "R11 rx_bit after reset", int'(rx_bit), 1);

        // R2/R3/R4: no edges, P=2 A=3 B=3
        setup(2, 3, 3, 4, 0, 1'b0);
        wait_bit(t);
        push(t + 6*qn, 1'b1, "R3 nominal sample point");
        push(t + 15*qn, 1'b1, "R2 nominal bit length");
        wait_bit(t2);
        check(t2 - t == 9*qn, "R4 tx strobe spacing", t2 - t, 9*qn);
        drain();

        // R5: late edge in propagation segment, error 2, jump width 4
        setup(2, 3, 3, 4, 0, 1'b0);
        wait_bit(t);
        goto(t + 2*qn); rx_in = 1'b0;
        push(t + 8*qn, 1'b0, "R5 late edge lengthen by 2");
        push(t + 17*qn, 1'b0, "R5 following bit");
        drain();

        // R5: late edge in phase 1, error 5 clipped to jump width 2
        setup(2, 3, 3, 2, 0, 1'b0);
        wait_bit(t);
        goto(t + 5*qn); rx_in = 1'b0;
        push(t + 8*qn, 1'b0, "R5 late edge clipped to jump width");
        drain();

        // R6: early edge in phase 2, error 2 within jump width 4
        setup(2, 3, 3, 4, 0, 1'b0);
        wait_bit(t);
        push(t + 6*qn, 1'b1, "R6 sample before early edge");
        push(t + 13*qn, 1'b0, "R6 early edge restarts bit");
        goto(t + 7*qn); rx_in = 1'b0;
        drain();

        // R6: early edge error 6 beyond jump width 2, P=1 A=2 B=6
        setup(1, 2, 6, 2, 0, 1'b0);
        wait_bit(t);
        push(t + 4*qn, 1'b1, "R6 sample before early edge");
        push(t + 12*qn, 1'b0, "R6 phase 2 shortened by jump width");
        push(t + 22*qn, 1'b0, "R6 next bit nominal");
        goto(t + 4*qn); rx_in = 1'b0;
        drain();

        // R7: own dominant bit blocks resync
        setup(2, 3, 3, 4, 0, 1'b0);
        wait_bit(t);
        tx_bit = 1'b0;
        goto(t + 2*qn); rx_in = 1'b0;
        push(t + 6*qn, 1'b0, "R7 no resync while transmitting dominant");
        push(t + 15*qn, 1'b0, "R7 following bit");
        drain();

        // R8: second edge before sample point ignored, P=4 A=2 B=3
        setup(4, 2, 3, 4, 0, 1'b0);
        wait_bit(t);
        goto(t + 1*qn); rx_in = 1'b0;
        goto(t + 2*qn); rx_in = 1'b1;
        goto(t + 3*qn); rx_in = 1'b0;
        push(t + 8*qn, 1'b0, "R8 only first edge used");
        push(t + 18*qn, 1'b0, "R8 following bit");
        drain();

        // R9: hard sync in phase 1 with jump width 1
        setup(2, 3, 3, 1, 0, 1'b0);
        wait_bit(t);
        bus_idle = 1'b1;
        goto(t + 4*qn); rx_in = 1'b0;
        push(t + 10*qn, 1'b0, "R9 hard sync restarts bit");
        push(t + 19*qn, 1'b0, "R9 following bit");
        drain();

        // R10: single-quantum glitch at the sample quantum, triple vote
        setup(2, 3, 3, 4, 0, 1'b1);
        wait_bit(t);
        tx_bit = 1'b0;
        push(t + 6*qn, 1'b1, "R10 triple outvotes one low sample");
        goto(t + 5*qn); rx_in = 1'b0;
        goto(t + 6*qn); rx_in = 1'b1;
        drain();

        // R10: same glitch, single sample
        setup(2, 3, 3, 4, 0, 1'b0);
        wait_bit(t);
        tx_bit = 1'b0;
        push(t + 6*qn, 1'b0, "R10 single sample takes last value");
        goto(t + 5*qn); rx_in = 1'b0;
        goto(t + 6*qn); rx_in = 1'b1;
        drain();

        // R10: two low of three, triple vote
        setup(2, 3, 3, 4, 0, 1'b1);
        wait_bit(t);
        tx_bit = 1'b0;
        push(t + 6*qn, 1'b0, "R10 triple majority low");
        goto(t + 4*qn); rx_in = 1'b0;
        goto(t + 6*qn); rx_in = 1'b1;
        drain();

        // R1: prescaler 2 gives 6-clock quanta
        setup(2, 3, 3, 4, 2, 1'b0);
        wait_bit(t);
        push(t + 6*qn, 1'b1, "R1 quantum of 6 clocks");
        push(t + 15*qn, 1'b1, "R1 bit of 54 clocks");
        wait_bit(t2);
        check(t2 - t == 54, "R1 tx strobe spacing", t2 - t, 54);
        drain();

        // R12: one-clock low pulse between quantum boundaries is invisible
        setup(2, 3, 3, 4, 2, 1'b0);
        wait_bit(t);
        push(t + 6*qn, 1'b1, "R12 short pulse not an edge");
        goto(t + 2*qn + 2); rx_in = 1'b0;
        goto(t + 2*qn + 3); rx_in = 1'b1;
        drain();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule